// File: doc/BRIEF.md
# Edge-Interrupt GPIO Controller

This block manages 28 general-purpose pins from a simple synchronous register bus. Software can read the synchronized level of every pin, choose each pin's direction, and change the output latches through separate write-one-to-set and write-one-to-clear registers. Because these registers are separate, several masters never need a read-modify-write sequence.

Each pin can be armed to detect a rising transition, a falling transition or both. A detected edge sets a sticky status bit. The bit stays set until software writes a one to it. Pins 0 to 10 each have their own interrupt line that follows their status bit. Pins 11 to 27 share one line. A wake line is raised whenever a pending status bit belongs to a pin whose wake enable is set.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `pin_out`, `pin_oe`, `irq_direct`, `irq_shared` and `wake` are zero. Every register reads as zero after reset.
- R2: Offset 0x00 returns the pin levels after a two-flop synchronizer, whatever the direction of each pin. A change on `pin_in` before clock edge k appears on `bus_rdata` after edge k+2 while the address is held.
- R3: A write to offset 0x08 sets each latch bit whose data bit is 1. A write to offset 0x0C clears each latch bit whose data bit is 1. Zero data bits leave the latch unchanged. `pin_out` shows the latch, and it changes only on these writes.
- R4: Offset 0x04 holds the direction, where bit 1 means output. `pin_oe` equals this register. A latch written while the pin is an input keeps its value when the pin becomes an output.
- R5: Offset 0x10 enables rising-edge detection and offset 0x14 enables falling-edge detection, per pin. An edge is the synchronized level differing from its value one clock earlier. With both enables set, either transition is detected. With neither set, no transition is detected.
- R6: Offset 0x18 is the sticky edge status. A detected edge sets the pin's bit on the clock after the synchronized level changes. Writing 1 to a bit clears it. Writing 0 has no effect. No bit falls without a clear write.
- R7: `irq_direct[i]` equals status bit i for pins 0 to 10, with no added delay.
- R8: `irq_shared` is the OR of status bits 11 to 27, registered one clock later.
- R9: Offset 0x1C holds the wake enables. `wake` is the OR of status ANDed with the wake enables, registered one clock later.
- R10: `bus_rdata` is registered and shows the register at the address of the previous cycle. Offsets 0x08, 0x0C and any unmapped address read as zero. Bits 28 to 31 always read as zero.
- R11: When a new edge and a clear write reach the same status bit on the same clock, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the current address |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 28 | Pin levels from the pads (asynchronous) |
| pin_out | output | 28 | Output latch values |
| pin_oe | output | 28 | Output enables (1 = drive) |
| irq_direct | output | 11 | Dedicated interrupts for pins 0 to 10 |
| irq_shared | output | 1 | Combined interrupt for pins 11 to 27 |
| wake | output | 1 | Wake request |

## Verification
The hardest case to reach is a clear write that lands on exactly the clock on which a new edge sets the same status bit. An edge is detected three clock edges after the pad changes, so the bench first makes the bit pending. It then toggles the pad and issues the clear write two cycles later, so that both events are sampled on one clock. Long randomized runs of writes and pad toggles also cover bursts of edges on the shared pins and on pins with wake enabled. A behavioural model checks the outputs on every cycle.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int GPIO_ADDR_W = 5;

  typedef enum logic [GPIO_ADDR_W-1:0] {
    REG_LEVEL = 5'h00,
    REG_DIR   = 5'h04,
    REG_SET   = 5'h08,
    REG_CLR   = 5'h0C,
    REG_RISE  = 5'h10,
    REG_FALL  = 5'h14,
    REG_STAT  = 5'h18,
    REG_WAKE  = 5'h1C
  } gpio_reg_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 28
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
  parameter int W = 28
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] level,
  input  logic [W-1:0] rise_en,
  input  logic [W-1:0] fall_en,
  output logic [W-1:0] hit
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= level;
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    assign hit[i] = (rise_en[i] &  level[i] & ~prev_q[i]) |
                    (fall_en[i] & ~level[i] &  prev_q[i]);
  end
endmodule

// File: rtl/gpio_status.sv
module gpio_status #(
  parameter int W = 28
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] status
);
  always_ff @(posedge clk) begin
    if (rst) status <= '0;
    else     status <= (status & ~clr_vec) | set_vec;
  end
endmodule

// File: rtl/gpio_irq_out.sv
module gpio_irq_out #(
  parameter int W          = 28,
  parameter int NUM_DIRECT = 11
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [W-1:0]          status,
  input  logic [W-1:0]          wake_en,
  output logic [NUM_DIRECT-1:0] irq_direct,
  output logic                  irq_shared,
  output logic                  wake
);
  assign irq_direct = status[NUM_DIRECT-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_shared <= 1'b0;
      wake       <= 1'b0;
    end else begin
      irq_shared <= |status[W-1:NUM_DIRECT];
      wake       <= |(status & wake_en);
    end
  end
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_pkg::*;
#(
  parameter int NUM_PINS   = 28,
  parameter int NUM_DIRECT = 11,
  parameter int DATA_W     = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_we,
  input  logic [GPIO_ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0]      bus_wdata,
  output logic [DATA_W-1:0]      bus_rdata,
  input  logic [NUM_PINS-1:0]    pin_in,
  output logic [NUM_PINS-1:0]    pin_out,
  output logic [NUM_PINS-1:0]    pin_oe,
  output logic [NUM_DIRECT-1:0]  irq_direct,
  output logic                   irq_shared,
  output logic                   wake
);
  logic [NUM_PINS-1:0] wdata;
  logic                unused_hi;
  logic [NUM_PINS-1:0] level_sync;
  logic [NUM_PINS-1:0] latch_q, dir_q, rise_q, fall_q, wake_en_q;
  logic [NUM_PINS-1:0] edge_hit, status_q, status_clr;
  logic [NUM_PINS-1:0] rd_sel;
  logic                wr_dir, wr_set, wr_clr, wr_rise, wr_fall, wr_stat, wr_wake;

  assign wdata     = bus_wdata[NUM_PINS-1:0];
  assign unused_hi = ^bus_wdata[DATA_W-1:NUM_PINS];

  assign wr_dir  = bus_we && (bus_addr == REG_DIR);
  assign wr_set  = bus_we && (bus_addr == REG_SET);
  assign wr_clr  = bus_we && (bus_addr == REG_CLR);
  assign wr_rise = bus_we && (bus_addr == REG_RISE);
  assign wr_fall = bus_we && (bus_addr == REG_FALL);
  assign wr_stat = bus_we && (bus_addr == REG_STAT);
  assign wr_wake = bus_we && (bus_addr == REG_WAKE);

  assign status_clr = wr_stat ? wdata : '0;

  gpio_sync #(.W(NUM_PINS)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pin_in),
    .sync_out (level_sync)
  );

  gpio_edge_detect #(.W(NUM_PINS)) u_edge (
    .clk     (clk),
    .rst     (rst),
    .level   (level_sync),
    .rise_en (rise_q),
    .fall_en (fall_q),
    .hit     (edge_hit)
  );

  gpio_status #(.W(NUM_PINS)) u_status (
    .clk     (clk),
    .rst     (rst),
    .set_vec (edge_hit),
    .clr_vec (status_clr),
    .status  (status_q)
  );

  gpio_irq_out #(.W(NUM_PINS), .NUM_DIRECT(NUM_DIRECT)) u_irq (
    .clk        (clk),
    .rst        (rst),
    .status     (status_q),
    .wake_en    (wake_en_q),
    .irq_direct (irq_direct),
    .irq_shared (irq_shared),
    .wake       (wake)
  );

  // Configuration registers and output latch
  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q   <= '0;
      dir_q     <= '0;
      rise_q    <= '0;
      fall_q    <= '0;
      wake_en_q <= '0;
    end else begin
      if (wr_set)  latch_q   <= latch_q | wdata;
      if (wr_clr)  latch_q   <= latch_q & ~wdata;
      if (wr_dir)  dir_q     <= wdata;
      if (wr_rise) rise_q    <= wdata;
      if (wr_fall) fall_q    <= wdata;
      if (wr_wake) wake_en_q <= wdata;
    end
  end

  always_comb begin
    case (bus_addr)
      REG_LEVEL: rd_sel = level_sync;
      REG_DIR:   rd_sel = dir_q;
      REG_RISE:  rd_sel = rise_q;
      REG_FALL:  rd_sel = fall_q;
      REG_STAT:  rd_sel = status_q;
      REG_WAKE:  rd_sel = wake_en_q;
      default:   rd_sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= DATA_W'(rd_sel);
  end

  assign pin_out = latch_q;
  assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk
  import gpio_pkg::*;
#(
  parameter int NUM_PINS   = 28,
  parameter int NUM_DIRECT = 11
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   bus_we,
  input logic [GPIO_ADDR_W-1:0] bus_addr,
  input logic [NUM_PINS-1:0]    pin_out,
  input logic [NUM_PINS-1:0]    pin_oe,
  input logic [NUM_PINS-1:0]    status_q,
  input logic [NUM_PINS-1:0]    status_clr,
  input logic [NUM_PINS-1:0]    edge_hit,
  input logic [NUM_PINS-1:0]    wake_en_q,
  input logic                   irq_shared,
  input logic                   wake
);
  AST_OUT_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && (bus_addr == REG_SET || bus_addr == REG_CLR)) |=> $stable(pin_out)); // R3

  AST_OE_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && bus_addr == REG_DIR) |=> $stable(pin_oe)); // R4

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(status_q) & ~status_q & ~$past(status_clr)) == '0)); // R6

  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (rst)
    (edge_hit != '0) |=> ((status_q & $past(edge_hit)) == $past(edge_hit))); // R11

  AST_SHARED_OR: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_shared == (|$past(status_q[NUM_PINS-1:NUM_DIRECT])))); // R8

  AST_WAKE_GATE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (wake == (|($past(status_q) & $past(wake_en_q))))); // R9
endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(
  .NUM_PINS   (NUM_PINS),
  .NUM_DIRECT (NUM_DIRECT)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .pin_out    (pin_out),
  .pin_oe     (pin_oe),
  .status_q   (status_q),
  .status_clr (status_clr),
  .edge_hit   (edge_hit),
  .wake_en_q  (wake_en_q),
  .irq_shared (irq_shared),
  .wake       (wake)
);

// File: tb/test_gpio_edge_ctrl.sv
module test_gpio_edge_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 28;
  localparam int ND = 11;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_we = 1'b0;
  logic [4:0]    bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic [ND-1:0] irq_direct;
  logic          irq_shared, wake;

  int checks = 0;
  int failures = 0;
  bit started = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_edge_ctrl i_gpio_edge_ctrl (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_direct(irq_direct),
    .irq_shared(irq_shared), .wake(wake)
  );

  // Behavioural reference model
  logic [NP-1:0] m_s1, m_s2, m_prev, m_latch, m_dir, m_rise, m_fall, m_stat, m_wen;
  logic          m_shared, m_wake;
  logic [DW-1:0] m_rdata;
  logic [4:0]    m_rd_addr;

  function automatic logic [NP-1:0] model_read(input logic [4:0] a);
    case (a)
      5'h00: return m_s2;
      5'h04: return m_dir;
      5'h10: return m_rise;
      5'h14: return m_fall;
      5'h18: return m_stat;
      5'h1C: return m_wen;
      default: return '0;
    endcase
  endfunction

  always @(posedge clk) begin
    logic [NP-1:0] ev, w, clr;
    started = 1;
    if (rst) begin
      m_s1 = '0; m_s2 = '0; m_prev = '0; m_latch = '0; m_dir = '0;
      m_rise = '0; m_fall = '0; m_stat = '0; m_wen = '0;
      m_shared = 0; m_wake = 0; m_rdata = '0; m_rd_addr = '0;
    end else begin
      w   = bus_wdata[NP-1:0];
      ev  = (m_rise & m_s2 & ~m_prev) | (m_fall & ~m_s2 & m_prev);
      clr = (bus_we && bus_addr == 5'h18) ? w : '0;
      m_rdata   = {{(DW-NP){1'b0}}, model_read(bus_addr)};
      m_rd_addr = bus_addr;
      m_shared  = |m_stat[NP-1:ND];
      m_wake    = |(m_stat & m_wen);
      m_stat    = (m_stat & ~clr) | ev;
      m_prev    = m_s2;
      m_s2      = m_s1;
      m_s1      = pin_in;
      if (bus_we) begin
        case (bus_addr)
          5'h04: m_dir   = w;
          5'h08: m_latch = m_latch | w;
          5'h0C: m_latch = m_latch & ~w;
          5'h10: m_rise  = w;
          5'h14: m_fall  = w;
          5'h1C: m_wen   = w;
          default: ;
        endcase
      end
    end
  end

  task automatic check(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic string rd_tag(input logic [4:0] a);
    case (a)
      5'h00: return "R2";
      5'h04: return "R4";
      5'h10, 5'h14: return "R5";
      5'h18: return "R6";
      5'h1C: return "R9";
      default: return "R10";
    endcase
  endfunction

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      check("R3", "pin_out", DW'(pin_out), DW'(m_latch));
      check("R4", "pin_oe", DW'(pin_oe), DW'(m_dir));
      check("R7", "irq_direct", DW'(irq_direct), DW'(m_stat[ND-1:0]));
      check("R8", "irq_shared", DW'(irq_shared), DW'(m_shared));
      check("R9", "wake", DW'(wake), DW'(m_wake));
      check(rd_tag(m_rd_addr), "bus_rdata", bus_rdata, m_rdata);
    end
  end

  task automatic wr(input logic [4:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_we = 0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    idle(3);
    @(negedge clk) rst = 0;
    // R1: reset state
    check("R1", "pin_out after reset", DW'(pin_out), '0);
    check("R1", "irq lines after reset", DW'({irq_direct, irq_shared, wake}), '0);
    rd(5'h18, v); check("R1", "status after reset", v, '0);

    // R3/R4: preload latch while input, then switch to output
    wr(5'h08, 32'h0F0F_00F5);
    wr(5'h0C, 32'h0000_0005);
    check("R3", "latch set/clear", DW'(pin_out), 32'h0F0F_00F0);
    wr(5'h04, 32'h0000_FFFF);
    check("R4", "preloaded latch kept", DW'(pin_out), 32'h0F0F_00F0);
    rd(5'h04, v); check("R4", "direction readback", v, 32'h0000_FFFF);
    rd(5'h08, v); check("R10", "set reg reads zero", v, '0);
    wr(5'h04, 32'hFFFF_FFFF);
    rd(5'h04, v); check("R10", "upper bits zero", v, 32'h0FFF_FFFF);

    // R2: level readback independent of direction
    pin_in = 28'h0A5_5A5A;
    idle(4);
    rd(5'h00, v); check("R2", "level readback", v, 32'h00A5_5A5A);
    pin_in = '0; idle(4);

    // R5/R6: edge selection, pins 0..3 rise, 2..5 fall
    wr(5'h10, 32'h0000_000F);
    wr(5'h14, 32'h0000_003C);
    pin_in = 28'h0000_003F; idle(5);
    rd(5'h18, v); check("R5", "rising edges", v, 32'h0000_000F);
    pin_in = '0; idle(5);
    rd(5'h18, v); check("R5", "falling edges added", v, 32'h0000_003F);
    wr(5'h18, 32'h0000_0005);
    rd(5'h18, v); check("R6", "w1c partial", v, 32'h0000_003A);
    wr(5'h18, 32'hFFFF_FFFF);
    rd(5'h18, v); check("R6", "w1c all", v, '0);

    // R8/R9: shared pins and wake
    wr(5'h10, 32'h0FFF_FFFF);
    wr(5'h1C, 32'h0010_0000);
    pin_in = 28'h0010_0000; idle(5);
    check("R8", "shared irq from pin 20", DW'(irq_shared), 32'd1);
    check("R9", "wake from pin 20", DW'(wake), 32'd1);
    wr(5'h18, 32'h0010_0000); idle(2);
    check("R8", "shared irq cleared", DW'(irq_shared), 32'd0);

    // R11: clear and new edge on the same clock (pin 1)
    wr(5'h14, 32'h0000_0002);
    pin_in = 28'h0010_0002; idle(4);
    pin_in = 28'h0010_0000;          // falling edge; hit seen two clocks later
    @(negedge clk);
    @(negedge clk);
    bus_we = 1; bus_addr = 5'h18; bus_wdata = 32'h0000_0002;
    @(negedge clk);
    bus_we = 0; bus_wdata = '0;
    rd(5'h18, v); check("R11", "edge wins over clear", v & 32'h2, 32'h2);

    // Randomized traffic, compared every cycle by the model
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      bus_we    = ($urandom % 3) == 0;
      bus_addr  = 5'($urandom % 9) << 2;
      if (($urandom % 16) == 0) bus_addr = 5'($urandom);
      bus_wdata = $urandom;
      if (($urandom % 4) == 0) pin_in = pin_in ^ NP'($urandom);
    end
    @(negedge clk) bus_we = 0;
    idle(4);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule